// File: doc/BRIEF.md
# Address Bus Parity Generator and Checker

This block guards a 32-bit shared address bus with one odd-parity bit per address byte. When the local agent owns the bus, the block registers the outgoing address, derives four parity bits from it and raises a parity output enable in the same cycle as the address output enable. When another agent places an address on the bus, the block checks the incoming parity bits against the snooped address and records every failing byte lane.

Generation and checking each have their own enable input. A detected error follows one of two paths, chosen by a mode input. It can be a single-cycle machine-check request, which software may recover from. It can also be a sticky checkstop flag that only reset removes. The pad tristate cells, arbitration and exception handling sit outside this block.

Top module: `addr_parity_unit`

## Requirements
- R1: Bit k of `ap_o` is the odd-parity bit of byte lane k of `addr_o`. Lane 0 is the most significant byte, `addr_o[31:24]`, and lane 3 is `addr_o[7:0]`. Across the 8 address bits plus their parity bit, the count of ones is odd.
- R2: `addr_oe_o` equals `mst_vld_i` from the previous clock edge, and `addr_o` captures `mst_addr_i` on that edge. `ap_oe_o` is high only when `addr_oe_o` is high, so the parity lanes are released in the same cycle as the address.
- R3: When `cfg_gen_en_i` was low at the capturing edge, `ap_oe_o` is low and `ap_o` reads all zeros, even while the address is driven.
- R4: On an edge where `snp_vld_i` and `cfg_chk_en_i` are high and the bus is not self-driven, every lane whose 8 snooped bits plus `snp_ap_i[k]` hold an even count of ones sets bit k of `err_lanes_o` in the next cycle.
- R5: With `cfg_chk_en_i` low, or `snp_vld_i` low, bad snoop parity changes neither `err_lanes_o`, `mc_req_o` nor `checkstop_o`.
- R6: While `addr_oe_o` is high, a snooped address is not checked and raises no error.
- R7: `err_lanes_o` holds and accumulates (bitwise OR) failing lanes until `err_clr_i` is sampled high. When a clear and a new error fall on the same edge, the new error's lanes remain set.
- R8: With `cfg_mc_mode_i` = 1, a detected error drives `mc_req_o` high for exactly the one cycle after the sampling edge, and `checkstop_o` is not set.
- R9: With `cfg_mc_mode_i` = 0, a detected error sets `checkstop_o`, which stays high through later cycles and through `err_clr_i` until reset, and `mc_req_o` stays low.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_gen_en_i | input | 1 | Parity generation enable |
| cfg_chk_en_i | input | 1 | Snoop parity check enable |
| cfg_mc_mode_i | input | 1 | Error action: 1 = machine-check pulse, 0 = checkstop |
| mst_vld_i | input | 1 | Local master has a valid address to drive |
| mst_addr_i | input | 32 | Address to drive as master |
| addr_o | output | 32 | Registered address toward the pads |
| addr_oe_o | output | 1 | Address output enable |
| ap_o | output | 4 | Generated parity lanes, lane 0 = bit 0 |
| ap_oe_o | output | 1 | Parity lane output enable |
| snp_vld_i | input | 1 | Snooped address strobe |
| snp_addr_i | input | 32 | Snooped address |
| snp_ap_i | input | 4 | Snooped parity lanes |
| err_clr_i | input | 1 | Clear the error-lane record |
| err_lanes_o | output | 4 | Accumulated failing lanes |
| mc_req_o | output | 1 | Machine-check request pulse |
| checkstop_o | output | 1 | Sticky checkstop flag |

## Verification
A clear of the error record and a new parity failure can fall on the same edge. The bench provokes this by asserting `err_clr_i` in the same cycle as a snoop with a corrupted lane 3 while older lanes are set. It expects the old lanes gone and only the new lane left. A second overlap is a snoop with bad parity while the block is driving the bus. There the expected error record stays unchanged and no error action appears.

// File: rtl/addr_parity_pkg.sv
package addr_parity_pkg;
  typedef enum logic {
    ACT_CHECKSTOP = 1'b0,
    ACT_MCHECK    = 1'b1
  } err_act_e;
endpackage

// File: rtl/ap_gen.sv
module ap_gen #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int NL = ADDR_W / LANE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NL-1:0]     par_o
);
  // lane 0 = most significant byte
  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign par_o[k] = ~^addr_i[ADDR_W-1-k*LANE_W -: LANE_W];
  end
endmodule

// File: rtl/ap_chk.sv
module ap_chk #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int NL = ADDR_W / LANE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NL-1:0]     ap_i,
  output logic [NL-1:0]     bad_o
);
  // even ones count over byte + parity bit marks a bad lane
  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign bad_o[k] = ~^{addr_i[ADDR_W-1-k*LANE_W -: LANE_W], ap_i[k]};
  end
endmodule

// File: rtl/ap_err_route.sv
module ap_err_route
  import addr_parity_pkg::*;
#(
  parameter int NL = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [NL-1:0] bad_i,
  input  logic          clr_i,
  input  logic          mode_i,
  output logic [NL-1:0] lanes_o,
  output logic          mc_req_o,
  output logic          checkstop_o
);
  logic          fire;
  logic [NL-1:0] new_bad;
  err_act_e      act;

  assign new_bad = sample_i ? bad_i : '0;
  assign fire    = |new_bad;
  assign act     = err_act_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lanes_o     <= '0;
      mc_req_o    <= 1'b0;
      checkstop_o <= 1'b0;
    end else begin
      // set wins over clear
      lanes_o  <= (clr_i ? '0 : lanes_o) | new_bad;
      mc_req_o <= fire && (act == ACT_MCHECK);
      if (fire && (act == ACT_CHECKSTOP)) checkstop_o <= 1'b1;
    end
  end
endmodule

// File: rtl/addr_parity_unit.sv
module addr_parity_unit #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int NL = ADDR_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_gen_en_i,
  input  logic              cfg_chk_en_i,
  input  logic              cfg_mc_mode_i,
  input  logic              mst_vld_i,
  input  logic [ADDR_W-1:0] mst_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [NL-1:0]     ap_o,
  output logic              ap_oe_o,
  input  logic              snp_vld_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [NL-1:0]     snp_ap_i,
  input  logic              err_clr_i,
  output logic [NL-1:0]     err_lanes_o,
  output logic              mc_req_o,
  output logic              checkstop_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              addr_oe_q;
  logic              ap_oe_q;
  logic [NL-1:0]     gen_par;
  logic [NL-1:0]     snp_bad;
  logic              sample;

  // address and both enables switch on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      addr_oe_q <= 1'b0;
      ap_oe_q   <= 1'b0;
    end else begin
      if (mst_vld_i) addr_q <= mst_addr_i;
      addr_oe_q <= mst_vld_i;
      ap_oe_q   <= mst_vld_i && cfg_gen_en_i;
    end
  end

  ap_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_gen (
    .addr_i (addr_q),
    .par_o  (gen_par)
  );

  assign addr_o    = addr_q;
  assign addr_oe_o = addr_oe_q;
  assign ap_oe_o   = ap_oe_q;
  assign ap_o      = ap_oe_q ? gen_par : '0;

  ap_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .addr_i (snp_addr_i),
    .ap_i   (snp_ap_i),
    .bad_o  (snp_bad)
  );

  // own transmitted address is never checked
  assign sample = snp_vld_i && cfg_chk_en_i && !addr_oe_q;

  ap_err_route #(.NL(NL)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample),
    .bad_i       (snp_bad),
    .clr_i       (err_clr_i),
    .mode_i      (cfg_mc_mode_i),
    .lanes_o     (err_lanes_o),
    .mc_req_o    (mc_req_o),
    .checkstop_o (checkstop_o)
  );
endmodule

// File: rtl/addr_parity_unit_chk.sv
module addr_parity_unit_chk #(
  parameter int NL = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_gen_en_i,
  input logic          cfg_chk_en_i,
  input logic          addr_oe_o,
  input logic          ap_oe_o,
  input logic          err_clr_i,
  input logic [NL-1:0] err_lanes_o,
  input logic          mc_req_o,
  input logic          checkstop_o
);
  assert_ap_oe_with_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_oe_o |-> addr_oe_o);

  assert_gen_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_gen_en_i |=> !ap_oe_o);

  assert_chk_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_chk_en_i && !err_clr_i) |=> ($stable(err_lanes_o) && !mc_req_o));

  assert_self_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_oe_o && !err_clr_i) |=> ($stable(err_lanes_o) && !mc_req_o));

  assert_lanes_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> ((err_lanes_o & $past(err_lanes_o)) == $past(err_lanes_o)));

  assert_mc_has_lanes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_req_o |-> (err_lanes_o != '0));

  assert_checkstop_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> checkstop_o);
endmodule

bind addr_parity_unit addr_parity_unit_chk #(.NL(NL)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_gen_en_i (cfg_gen_en_i),
  .cfg_chk_en_i (cfg_chk_en_i),
  .addr_oe_o    (addr_oe_o),
  .ap_oe_o      (ap_oe_o),
  .err_clr_i    (err_clr_i),
  .err_lanes_o  (err_lanes_o),
  .mc_req_o     (mc_req_o),
  .checkstop_o  (checkstop_o)
);

// File: tb/addr_parity_unit_tb.sv
module addr_parity_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_gen_en_i = 1'b0, cfg_chk_en_i = 1'b0, cfg_mc_mode_i = 1'b0;
  logic        mst_vld_i = 1'b0;
  logic [31:0] mst_addr_i = '0;
  logic [31:0] addr_o;
  logic        addr_oe_o;
  logic [3:0]  ap_o;
  logic        ap_oe_o;
  logic        snp_vld_i = 1'b0;
  logic [31:0] snp_addr_i = '0;
  logic [3:0]  snp_ap_i = '0;
  logic        err_clr_i = 1'b0;
  logic [3:0]  err_lanes_o;
  logic        mc_req_o, checkstop_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  addr_parity_unit u_dut (.*);

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  ap;
    logic        aoe, poe;
    logic [3:0]  lanes;
    logic        mc, cs;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  exp_t me;

  // bench model state
  logic [31:0] m_addr = '0;
  logic        m_aoe = 0, m_poe = 0, m_mc = 0, m_cs = 0;
  logic [3:0]  m_lanes = '0;

  // odd-parity bit for lane k (lane 0 = bits 31:24) by counting ones
  function automatic logic [3:0] odd_par(input logic [31:0] a);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(a[31 - 8*k - b]);
      p[k] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic step(input logic mv, input logic [31:0] maddr, input logic gen,
                      input logic sv, input logic [31:0] saddr, input logic [3:0] sap,
                      input logic chk, input logic mode, input logic clr, input string req);
    logic [3:0] bad;
    logic       fire;
    exp_t       e;
    mst_vld_i = mv; mst_addr_i = maddr; cfg_gen_en_i = gen;
    snp_vld_i = sv; snp_addr_i = saddr; snp_ap_i = sap;
    cfg_chk_en_i = chk; cfg_mc_mode_i = mode; err_clr_i = clr;
    bad  = odd_par(saddr) ^ sap;
    fire = sv && chk && !m_aoe && (bad != 0);
    m_lanes = (clr ? 4'b0 : m_lanes) | (fire ? bad : 4'b0);
    m_mc = fire && mode;
    if (fire && !mode) m_cs = 1'b1;
    if (mv) m_addr = maddr;
    m_aoe = mv;
    m_poe = mv && gen;
    @(posedge clk_i);
    #1;
    e.addr = m_addr; e.ap = m_poe ? odd_par(m_addr) : 4'b0;
    e.aoe = m_aoe; e.poe = m_poe; e.lanes = m_lanes;
    e.mc = m_mc; e.cs = m_cs; e.req = req;
    sb_q.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic idle(input logic gen, input logic chk, input logic mode, input string req);
    step(0, '0, gen, 0, '0, '0, chk, mode, 0, req);
  endtask

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      me = sb_q.pop_front();
      checks++;
      if (addr_oe_o !== me.aoe || ap_oe_o !== me.poe || ap_o !== me.ap ||
          (me.aoe && addr_o !== me.addr) || err_lanes_o !== me.lanes ||
          mc_req_o !== me.mc || checkstop_o !== me.cs) begin
        errors++;
        $display("FAIL %s: got aoe=%b poe=%b ap=%b addr=%h lanes=%b mc=%b cs=%b exp aoe=%b poe=%b ap=%b addr=%h lanes=%b mc=%b cs=%b",
                 me.req, addr_oe_o, ap_oe_o, ap_o, addr_o, err_lanes_o, mc_req_o, checkstop_o,
                 me.aoe, me.poe, me.ap, me.addr, me.lanes, me.mc, me.cs);
      end
    end
  end

  task automatic check_reset(input string req);
    checks++;
    if ({addr_oe_o, ap_oe_o, ap_o, err_lanes_o, mc_req_o, checkstop_o} !== '0) begin
      errors++;
      $display("FAIL %s: reset outputs aoe=%b poe=%b ap=%b lanes=%b mc=%b cs=%b exp all zero",
               req, addr_oe_o, ap_oe_o, ap_o, err_lanes_o, mc_req_o, checkstop_o);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_addr = '0; m_aoe = 0; m_poe = 0; m_mc = 0; m_cs = 0; m_lanes = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] a;
    @(negedge clk_i);
    do_reset();
    check_reset("R10");

    // R1/R2: master drive with generation on
    step(1, 32'h0000_0000, 1, 0, '0, '0, 1, 1, 0, "R1 zero address");
    step(1, 32'h0103_07FF, 1, 0, '0, '0, 1, 1, 0, "R1 lane order");
    step(1, 32'h8000_0001, 1, 0, '0, '0, 1, 1, 0, "R1 single ones");
    for (int i = 0; i < 16; i++) begin
      a = $urandom;
      step(1, a, 1, 0, '0, '0, 1, 1, 0, "R1 random");
    end
    step(0, 32'hFFFF_FFFF, 1, 0, '0, '0, 1, 1, 0, "R2 release");
    // R3: generation disabled
    step(1, 32'h1234_5678, 0, 0, '0, '0, 1, 1, 0, "R3 gen off");
    step(0, '0, 1, 0, '0, '0, 1, 1, 0, "R2 release after R3");

    // R4: snoop checking
    a = 32'hDEAD_BEEF;
    step(0, '0, 1, 1, a, odd_par(a), 1, 1, 0, "R4 good parity");
    step(0, '0, 1, 1, a, odd_par(a) ^ 4'b0100, 1, 1, 0, "R4 R8 bad lane 2");
    idle(1, 1, 1, "R8 pulse ends R7 held");
    step(0, '0, 1, 1, a, odd_par(a) ^ 4'b0001, 1, 1, 0, "R7 accumulate lane 0");
    // R5: check disabled / strobe low
    step(0, '0, 1, 1, a, odd_par(a) ^ 4'b1000, 0, 1, 0, "R5 chk off");
    step(0, '0, 1, 0, a, odd_par(a) ^ 4'b1000, 1, 1, 0, "R5 strobe low");
    // R6: self-driven bus not checked
    step(1, 32'h0F0F_0F0F, 1, 0, '0, '0, 1, 1, 0, "R6 start driving");
    step(1, 32'h0F0F_0F0F, 1, 1, a, odd_par(a) ^ 4'b0010, 1, 1, 0, "R6 snoop while driving");
    step(0, '0, 1, 0, '0, '0, 1, 1, 0, "R6 release");
    // R7: clear, then clear colliding with new error
    step(0, '0, 1, 0, '0, '0, 1, 1, 1, "R7 clear");
    step(0, '0, 1, 1, a, odd_par(a) ^ 4'b0011, 1, 1, 0, "R7 two lanes");
    step(0, '0, 1, 1, a, odd_par(a) ^ 4'b1000, 1, 1, 1, "R7 clear with new error");
    // R9: checkstop mode
    step(0, '0, 1, 1, a, odd_par(a) ^ 4'b1111, 1, 0, 0, "R9 checkstop set");
    idle(1, 1, 0, "R9 sticky");
    step(0, '0, 1, 0, '0, '0, 1, 0, 1, "R9 survives clear");
    idle(1, 1, 1, "R9 still set");
    do_reset();
    check_reset("R9 R10 reset clears");
    idle(1, 1, 1, "R10 idle after reset");

    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule